// File: doc/BRIEF.md
# Pulse-Position Command Frame Decoder

This block recovers command frames that a reader sends to a card by briefly dropping its field. A front end samples the field and delivers groups of four samples, one group per half of a bit slot, with a set sample bit meaning the field was low. The decoder waits for a quiet field and then locks onto the first drop it sees. The position of the drop in the start symbol selects the coding for the rest of the frame. In one coding, a drop in one of four slots carries two bits. In the other, a drop in one of 256 slots carries a whole byte.

Each recovered byte appears on a one-cycle strobe. For every byte, an odd-parity bit is shifted into an accumulator so that downstream logic can log it beside the byte. A closing drop in the first half of the second slot ends the frame. Timing violations raise an error pulse and return the decoder to the idle, unsynchronised state.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: Out of idle, a group with any set bit starts a frame only after at least QUIET_MIN (8) consecutive qualified groups with all bits clear. An earlier set bit restarts the quiet count from zero and produces no output.
- R2: The start group fixes the sync bit. This is the highest-numbered set bit (bit 3 is earliest in time). Every later group in the frame is judged only by that bit, and its other bits have no effect.
- R3: The start group is the first half of slot 1, and half-slot groups then alternate. A drop in the second half of slot s records position s. After four slots of the start symbol, position 4 selects the 256-slot coding and position 3 selects the 4-slot coding. Any other position gives a frame_err pulse and a return to idle.
- R4: In the 4-slot coding, each symbol gives the value (position-1) in the range 0..3. Symbols fill a byte least significant pair first: the first symbol lands in bits 1:0 and the fourth in bits 7:6. The byte is strobed after the fourth symbol.
- R5: In the 256-slot coding, each symbol of 256 slots gives byte_data = position-1.
- R6: par_acc clears at a frame start. For each strobed byte it shifts left by one and takes in the odd-parity bit, which is 1 when the byte has an even number of ones.
- R7: In a frame with at least one byte, a drop in the first half of a slot when exactly one slot of the current symbol has completed ends the frame. This gives one frame_done pulse and a return to idle.
- R8: The same end-of-frame drop with no byte received strobes the marker byte 0xF0, sets par_acc to 1, sets byte_count to 1, gives no frame_done and returns to idle.
- R9: After the start symbol, the following are errors: a first-half drop other than the end-of-frame case, a second drop within one symbol, or a symbol that completes with no drop. Each gives a single frame_err pulse with no byte strobe and a return to idle.
- R10: byte_count counts the bytes of the current frame and saturates at MAX_BYTES (32). Bytes beyond that are still strobed.
- R11: Groups with smp_vld low are ignored, and no output pulses in the following cycle.
- R12: Under reset, all strobes, byte_count and par_acc are zero. Every output pulse appears in the cycle after the group that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Qualifies smp for this cycle |
| smp | input | 4 | Half-slot sample group, 1 = field dropped, bit 3 earliest |
| byte_vld | output | 1 | One-cycle strobe for byte_data |
| byte_data | output | 8 | Recovered byte or marker |
| byte_count | output | 6 | Bytes in current frame, saturating |
| par_acc | output | 32 | Parity bit accumulator |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_err | output | 1 | One-cycle error pulse |

## Verification
A slot or half-phase counter that drifts by one shows up quickly. In the 4-slot coding it appears within one symbol as a changed bit pair. Otherwise it appears as a frame_err pulse in the cycle after the misjudged group. A wrong sync bit, or a lost mode flag, corrupts the first byte strobe of the frame. Parity or byte-count faults stay hidden until the strobe or frame_done, where par_acc and byte_count are compared against values that the bench computes from the byte stream.

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder #(
  parameter int QUIET_MIN = 8,
  parameter int MAX_BYTES = 32,
  parameter int PAR_W     = 32,
  parameter int WIDE_SPAN = 256
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 smp_vld,
  input  logic [3:0]                           smp,
  output logic                                 byte_vld,
  output logic [7:0]                           byte_data,
  output logic [$clog2(MAX_BYTES+1)-1:0]       byte_count,
  output logic [PAR_W-1:0]                     par_acc,
  output logic                                 frame_done,
  output logic                                 frame_err
);
  localparam int QW = $clog2(QUIET_MIN + 1);
  localparam int SW = $clog2(WIDE_SPAN + 1);
  localparam int CW = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {IDLE, SOF, RX} st_t;

  st_t           st;
  logic [QW-1:0] quiet_cnt;
  logic [1:0]    sync_idx, first_idx;
  logic          half2;
  logic          wide;
  logic [SW-1:0] slot_cnt, drop_pos, slot_nxt, pos_now, span;
  logic [7:0]    shreg, pos_m1, new_byte;
  logic [1:0]    sym_cnt;
  logic          drop;

  always_comb begin
    if (smp[3])      first_idx = 2'd3;
    else if (smp[2]) first_idx = 2'd2;
    else if (smp[1]) first_idx = 2'd1;
    else             first_idx = 2'd0;
  end

  assign drop     = smp[sync_idx];
  assign slot_nxt = slot_cnt + 1'b1;
  assign pos_now  = drop ? slot_nxt : drop_pos;
  assign span     = (st == RX && wide) ? SW'(WIDE_SPAN) : SW'(4);
  assign pos_m1   = pos_now[7:0] - 8'd1;
  assign new_byte = wide ? pos_m1 : {pos_m1[1:0], shreg[7:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      quiet_cnt  <= '0;
      sync_idx   <= '0;
      half2      <= 1'b0;
      wide       <= 1'b0;
      slot_cnt   <= '0;
      drop_pos   <= '0;
      shreg      <= '0;
      sym_cnt    <= '0;
      byte_vld   <= 1'b0;
      byte_data  <= '0;
      byte_count <= '0;
      par_acc    <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_vld   <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      if (smp_vld) begin
        if (st == IDLE) begin
          if (|smp) begin
            quiet_cnt <= '0;
            if (quiet_cnt == QW'(QUIET_MIN)) begin
              st         <= SOF;
              sync_idx   <= first_idx;
              half2      <= 1'b1;
              wide       <= 1'b0;
              slot_cnt   <= '0;
              drop_pos   <= '0;
              shreg      <= '0;
              sym_cnt    <= '0;
              byte_count <= '0;
              par_acc    <= '0;
            end
          end else if (quiet_cnt != QW'(QUIET_MIN)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
          end
        end else if (!half2) begin
          half2 <= 1'b1;
          if (drop) begin
            if (slot_cnt == SW'(1)) begin
              st <= IDLE;
              if (byte_count == '0) begin
                byte_vld   <= 1'b1;
                byte_data  <= 8'hF0;
                byte_count <= CW'(1);
                par_acc    <= PAR_W'(1);
              end else begin
                frame_done <= 1'b1;
              end
            end else if (st != SOF) begin
              st        <= IDLE;
              frame_err <= 1'b1;
            end
          end
        end else begin
          half2 <= 1'b0;
          if (drop && drop_pos != '0) begin
            st        <= IDLE;
            frame_err <= 1'b1;
          end else if (slot_nxt == span) begin
            slot_cnt <= '0;
            drop_pos <= '0;
            if (st == SOF) begin
              if (pos_now == SW'(4)) begin
                st   <= RX;
                wide <= 1'b1;
              end else if (pos_now == SW'(3)) begin
                st   <= RX;
                wide <= 1'b0;
              end else begin
                st        <= IDLE;
                frame_err <= 1'b1;
              end
            end else if (pos_now == '0) begin
              st        <= IDLE;
              frame_err <= 1'b1;
            end else begin
              if (!wide) begin
                shreg   <= (sym_cnt == 2'd3) ? 8'h00 : new_byte;
                sym_cnt <= sym_cnt + 1'b1;
              end
              if (wide || sym_cnt == 2'd3) begin
                byte_vld  <= 1'b1;
                byte_data <= new_byte;
                par_acc   <= {par_acc[PAR_W-2:0], ~^new_byte};
                if (byte_count != CW'(MAX_BYTES)) byte_count <= byte_count + 1'b1;
              end
            end
          end else begin
            slot_cnt <= slot_nxt;
            drop_pos <= pos_now;
          end
        end
      end
    end
  end

  // R6
  par_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> par_acc[0] == ~^byte_data);

  // R10
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(MAX_BYTES));

  // R11
  vld_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !byte_vld && !frame_done && !frame_err);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> st == IDLE && !frame_err && !byte_vld);

  // R1
  quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && smp_vld && (|smp) && quiet_cnt < QW'(QUIET_MIN)) |=> st == IDLE);

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> st == IDLE && !byte_vld);
endmodule

// File: tb/ppm_cmd_decoder_tb_top.sv
module ppm_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [3:0] smp = 4'h0;
  logic byte_vld, frame_done, frame_err;
  logic [7:0] byte_data;
  logic [5:0] byte_count;
  logic [31:0] par_acc;

  always #2 clk = ~clk;

  ppm_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_count(byte_count),
    .par_acc(par_acc), .frame_done(frame_done), .frame_err(frame_err));

  int ncmp = 0, nmis = 0, gcount = 0;
  int nrx, ndone, nerr, last_cnt;
  logic [31:0] last_par;
  logic [7:0] rx [0:63];
  logic [7:0] exp_b [0:39];
  logic [3:0] dg, qg;

  task automatic chk(input string tag, input int got, input int expv);
    ncmp++;
    if (got !== expv) begin
      nmis++;
      $display("FAIL %s got %0h exp %0h", tag, got, expv);
    end
  endtask

  task automatic observe();
    if (byte_vld) begin
      if (nrx < 64) rx[nrx] = byte_data;
      nrx++;
      last_par = par_acc;
      last_cnt = int'(byte_count);
    end
    if (frame_done) begin
      ndone++;
      last_par = par_acc;
      last_cnt = int'(byte_count);
    end
    if (frame_err) nerr++;
  endtask

  task automatic clear_obs();
    nrx = 0; ndone = 0; nerr = 0; last_cnt = 0; last_par = '0;
  endtask

  task automatic grp(input logic [3:0] g);
    gcount++;
    if (gcount % 11 == 0) begin
      smp_vld = 1'b0; smp = 4'hF;
      @(posedge clk); @(negedge clk);
      observe();
    end
    smp_vld = 1'b1; smp = g;
    @(posedge clk); @(negedge clk);
    observe();
    smp_vld = 1'b0; smp = 4'hF;
  endtask

  task automatic start_frame(input int sb, input bit wide, input int pos);
    dg = 4'(1 << sb);
    repeat (8) grp(4'h0);
    grp(dg | (dg - 4'h1));
    qg = ~dg;
    grp(qg);
    for (int s = 2; s <= 4; s++) begin
      grp(qg);
      grp((s == (wide ? 4 : pos)) ? dg : qg);
    end
  endtask

  task automatic sym(input int pos, input int span);
    for (int s = 1; s <= span; s++) begin
      grp(qg);
      grp((s == pos) ? dg : qg);
    end
  endtask

  task automatic eof();
    grp(qg); grp(qg); grp(dg);
  endtask

  function automatic logic opar(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic run_frame(input int sb, input bit wide, input int n);
    logic [31:0] ep;
    ep = '0;
    clear_obs();
    start_frame(sb, wide, 3);
    for (int i = 0; i < n; i++) begin
      if (wide) sym(int'(exp_b[i]) + 1, 256);
      else for (int k = 0; k < 4; k++) sym(((int'(exp_b[i]) >> (2 * k)) & 3) + 1, 4);
      ep = {ep[30:0], opar(exp_b[i])};
    end
    eof();
    chk(wide ? "R5 byte strobes" : "R4 byte strobes", nrx, n);
    for (int i = 0; i < n && i < 64; i++)
      chk(wide ? "R5 byte value" : "R4 R2 byte value", int'(rx[i]), int'(exp_b[i]));
    chk("R7 frame_done", ndone, 1);
    chk("R9 no error", nerr, 0);
    chk("R10 byte_count", last_cnt, (n > 32) ? 32 : n);
    chk("R6 par_acc", int'(last_par), int'(ep));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nmis++; ncmp++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset byte_vld", int'(byte_vld), 0);
    chk("R12 reset pulses", int'(frame_done | frame_err), 0);
    chk("R12 reset count", int'(byte_count), 0);
    chk("R12 reset par_acc", int'(par_acc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R2: sweep all byte values in the 4-slot coding, rotating sync bits
    for (int f = 0; f < 64; f++) begin
      for (int i = 0; i < 4; i++) exp_b[i] = 8'(4 * f + i);
      run_frame(f % 4, 1'b0, 4);
    end

    // R5: 256-slot coding over spread values
    for (int k = 0; k < 52; k += 2) begin
      exp_b[0] = 8'(k * 5);
      exp_b[1] = (k == 50) ? 8'hFF : 8'((k + 1) * 5);
      run_frame((k / 2) % 4, 1'b1, 2);
    end

    // R10: saturation
    for (int i = 0; i < 34; i++) exp_b[i] = 8'(i * 37 + 11);
    run_frame(2, 1'b0, 34);

    // R8: empty frame
    clear_obs();
    start_frame(1, 1'b0, 3);
    eof();
    chk("R8 marker strobes", nrx, 1);
    chk("R8 marker value", int'(rx[0]), 8'hF0);
    chk("R8 no done", ndone, 0);
    chk("R8 par_acc", int'(last_par), 1);
    chk("R8 count", last_cnt, 1);

    // R3: bad start position
    clear_obs();
    start_frame(3, 1'b0, 2);
    chk("R3 bad sof err", nerr, 1);
    chk("R3 bad sof bytes", nrx, 0);

    // R9: first-half drop in slot 1
    clear_obs();
    start_frame(0, 1'b0, 3);
    grp(dg);
    chk("R9 first half err", nerr, 1);

    // R9: symbol without drop
    clear_obs();
    start_frame(2, 1'b0, 3);
    sym(0, 4);
    chk("R9 empty symbol err", nerr, 1);
    chk("R9 empty symbol bytes", nrx, 0);

    // R9: two drops in one symbol
    clear_obs();
    start_frame(1, 1'b0, 3);
    grp(qg); grp(dg); grp(qg); grp(dg);
    chk("R9 double drop err", nerr, 1);

    // R1: quiet run too short
    clear_obs();
    repeat (5) grp(4'h0);
    grp(4'h8);
    repeat (7) grp(4'h0);
    grp(4'h8);
    repeat (20) grp(4'h0);
    chk("R1 no sync err", nerr, 0);
    chk("R1 no sync bytes", nrx + ndone, 0);

    // R11 R1: recovery frame after the errors
    exp_b[0] = 8'hA5; exp_b[1] = 8'h3C;
    run_frame(3, 1'b0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end
endmodule